// File: doc/BRIEF.md
# Nibble-Immediate Accumulator Processor

A compact processor core whose every instruction fits in a single byte. The high nibble of each byte selects the operation and the low nibble carries a 4-bit immediate. The core fetches bytes through one byte-wide memory port with an 8-bit address and 8-bit data, and runs one instruction at a time. Operations that change data work on an implicit accumulator. A second register, the base, points at a small constant or data window in memory.

A full 8-bit constant never appears inside one instruction. Software builds it in one of two ways. It can merge nibbles into the accumulator (set, shift, OR, or the shift-in-nibble operation). It can also load the constant from a pool of sixteen bytes located at the base register plus a 4-bit offset. Data memory is reached only by the load and store operations. All other operations act on registers alone.

Top module: `nibcpu_top`

## Requirements
- R1: While `rst` is high on a clock edge, the accumulator, base register and program counter clear to 0x00 and `halted` clears. `mem_addr` then shows 0x00 and `mem_we` is low.
- R2: Bits 7:4 of an instruction byte are the opcode and bits 3:0 are the immediate. Opcodes: 0x1 set, 0x2 shift-left, 0x3 OR, 0x4 shift-in-nibble, 0x5 copy to base, 0x6 load, 0x7 store, 0x8 add, 0x9 AND, 0xA XOR, 0xF halt.
- R3: Opcode 0x1 writes the zero-extended immediate into the accumulator, so an immediate of 0x9 gives 0x09.
- R4: Opcode 0x2 shifts the accumulator left by the immediate amount and fills with zeros. Amounts of 8 or more give 0x00, and an amount of 0 leaves the value unchanged.
- R5: Opcode 0x3 ORs the zero-extended immediate into the accumulator.
- R6: Opcode 0x4 sets the accumulator to {old accumulator bits 3:0, immediate}, so two of these build any byte.
- R7: Opcode 0x5 copies the accumulator into the base register (`base_o`).
- R8: Opcode 0x6 loads the accumulator from memory address (base + immediate) mod 256.
- R9: Opcode 0x7 writes the accumulator to address (base + immediate) mod 256. `mem_we` is high for exactly that one cycle and for no other instruction.
- R10: Opcode 0x8 adds the zero-extended immediate modulo 256. Opcode 0x9 ANDs the accumulator with the zero-extended immediate. Opcode 0xA XORs the zero-extended immediate into the accumulator.
- R11: A non-memory instruction takes 2 cycles (fetch, execute), and a load or store takes 3. The program counter starts at 0x00, steps by one per fetched byte and wraps from 0xFF to 0x00.
- R12: Opcode 0xF stops fetching. `halted` then stays high, `mem_addr` holds still and no write occurs until reset.
- R13: Opcode 0x0 and opcodes 0xB to 0xE change neither register nor memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory address: the PC during fetch, base+offset during an access |
| mem_rdata | input | 8 | Memory read data, combinational from `mem_addr` |
| mem_wdata | output | 8 | Store data (the accumulator) |
| mem_we | output | 1 | Write strobe, captured by memory on the rising edge |
| acc_o | output | 8 | Accumulator value |
| base_o | output | 8 | Base register value |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions assume a memory that returns read data in the same cycle as its address, and that reset is applied before the first fetch. They make no assumption about which bytes are present, because any byte decodes to some defined behaviour. The stimulus uses a behavioural array with an asynchronous read and a write on the rising edge. Each scenario holds reset while it loads its program, so the checks see a clean start. Every program is short enough to end on its halt byte well inside the per-run cycle limit. The exception is the wrap scenario, which runs a fixed cycle count instead.

// File: rtl/nibcpu_pkg.sv
package nibcpu_pkg;

    localparam int DW    = 8;
    localparam int AW    = 8;
    localparam int IMM_W = 4;
    localparam int OP_W  = DW - IMM_W;

    typedef logic [DW-1:0]    byte_t;
    typedef logic [AW-1:0]    addr_t;
    typedef logic [IMM_W-1:0] imm_t;
    typedef logic [OP_W-1:0]  op_t;

    localparam op_t OPC_NOP  = 4'h0;
    localparam op_t OPC_SET  = 4'h1;
    localparam op_t OPC_SHL  = 4'h2;
    localparam op_t OPC_OR   = 4'h3;
    localparam op_t OPC_SHIN = 4'h4;
    localparam op_t OPC_BASE = 4'h5;
    localparam op_t OPC_LOAD = 4'h6;
    localparam op_t OPC_STOR = 4'h7;
    localparam op_t OPC_ADD  = 4'h8;
    localparam op_t OPC_AND  = 4'h9;
    localparam op_t OPC_XOR  = 4'hA;
    localparam op_t OPC_HALT = 4'hF;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_MEM   = 2'd2,
        ST_STOP  = 2'd3
    } state_e;

    typedef enum logic [2:0] {
        ALU_PASS,
        ALU_SET,
        ALU_SHL,
        ALU_OR,
        ALU_SHIN,
        ALU_ADD,
        ALU_AND,
        ALU_XOR
    } alu_op_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    wr_acc;
        logic    wr_base;
        logic    is_load;
        logic    is_store;
        logic    is_halt;
    } dec_t;

    function automatic byte_t zext(input imm_t v);
        return {{(DW-IMM_W){1'b0}}, v};
    endfunction

    function automatic imm_t imm_of(input byte_t instr);
        return instr[IMM_W-1:0];
    endfunction

    function automatic op_t op_of(input byte_t instr);
        return instr[DW-1:IMM_W];
    endfunction

endpackage

// File: rtl/nibcpu_decode.sv
module nibcpu_decode
    import nibcpu_pkg::*;
(
    input  byte_t instr,
    output dec_t  dec
);
    always_comb begin
        dec = '{alu_op: ALU_PASS, wr_acc: 1'b0, wr_base: 1'b0,
                is_load: 1'b0, is_store: 1'b0, is_halt: 1'b0};
        unique case (op_of(instr))
            OPC_SET:  begin dec.alu_op = ALU_SET;  dec.wr_acc = 1'b1; end
            OPC_SHL:  begin dec.alu_op = ALU_SHL;  dec.wr_acc = 1'b1; end
            OPC_OR:   begin dec.alu_op = ALU_OR;   dec.wr_acc = 1'b1; end
            OPC_SHIN: begin dec.alu_op = ALU_SHIN; dec.wr_acc = 1'b1; end
            OPC_ADD:  begin dec.alu_op = ALU_ADD;  dec.wr_acc = 1'b1; end
            OPC_AND:  begin dec.alu_op = ALU_AND;  dec.wr_acc = 1'b1; end
            OPC_XOR:  begin dec.alu_op = ALU_XOR;  dec.wr_acc = 1'b1; end
            OPC_BASE: dec.wr_base  = 1'b1;
            OPC_LOAD: dec.is_load  = 1'b1;
            OPC_STOR: dec.is_store = 1'b1;
            OPC_HALT: dec.is_halt  = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/nibcpu_alu.sv
module nibcpu_alu
    import nibcpu_pkg::*;
(
    input  alu_op_e op,
    input  byte_t   acc,
    input  imm_t    imm,
    output byte_t   res
);
    byte_t ext;
    assign ext = zext(imm);

    always_comb begin
        unique case (op)
            ALU_SET:  res = ext;
            ALU_SHL:  res = acc << imm;
            ALU_OR:   res = acc | ext;
            ALU_SHIN: res = {acc[DW-IMM_W-1:0], imm};
            ALU_ADD:  res = acc + ext;
            ALU_AND:  res = acc & ext;
            ALU_XOR:  res = acc ^ ext;
            default:  res = acc;
        endcase
    end
endmodule

// File: rtl/nibcpu_seq.sv
module nibcpu_seq
    import nibcpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  dec_t   dec,
    output state_e state
);
    state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FETCH: nxt = ST_EXEC;
            ST_EXEC: begin
                if (dec.is_halt)
                    nxt = ST_STOP;
                else if (dec.is_load || dec.is_store)
                    nxt = ST_MEM;
                else
                    nxt = ST_FETCH;
            end
            ST_MEM:   nxt = ST_FETCH;
            ST_STOP:  nxt = ST_STOP;
            default:  nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end
endmodule

// File: rtl/nibcpu_top.sv
module nibcpu_top
    import nibcpu_pkg::*;
#(
    parameter logic [7:0] PC_RESET = 8'h00
)(
    input  logic       clk,
    input  logic       rst,
    output logic [7:0] mem_addr,
    input  logic [7:0] mem_rdata,
    output logic [7:0] mem_wdata,
    output logic       mem_we,
    output logic [7:0] acc_o,
    output logic [7:0] base_o,
    output logic       halted
);
    state_e state;
    addr_t  pc;
    byte_t  ir;
    byte_t  acc;
    byte_t  base;
    dec_t   dec;
    byte_t  alu_res;
    addr_t  data_addr;

    nibcpu_decode u_dec (
        .instr (ir),
        .dec   (dec)
    );

    nibcpu_alu u_alu (
        .op  (dec.alu_op),
        .acc (acc),
        .imm (imm_of(ir)),
        .res (alu_res)
    );

    nibcpu_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .dec   (dec),
        .state (state)
    );

    assign data_addr = base + zext(imm_of(ir));

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= PC_RESET;
            ir   <= '0;
            acc  <= '0;
            base <= '0;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir <= mem_rdata;
                    pc <= pc + addr_t'(1);
                end
                ST_EXEC: begin
                    if (dec.wr_acc)  acc  <= alu_res;
                    if (dec.wr_base) base <= acc;
                end
                ST_MEM: begin
                    if (dec.is_load) acc <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    assign mem_addr  = (state == ST_MEM) ? data_addr : pc;
    assign mem_we    = (state == ST_MEM) && dec.is_store;
    assign mem_wdata = acc;
    assign acc_o     = acc;
    assign base_o    = base;
    assign halted    = (state == ST_STOP);
endmodule

// File: rtl/nibcpu_checker.sv
module nibcpu_checker
    import nibcpu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input state_e     st,
    input logic [7:0] ir,
    input logic [7:0] acc,
    input logic [7:0] base,
    input logic [7:0] pc,
    input logic [7:0] mem_addr,
    input logic       mem_we,
    input logic       halted
);
    logic in_exec;
    assign in_exec = (st == ST_EXEC);

    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_no_write_halted_R12: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    assert_addr_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        (halted && $past(halted)) |-> $stable(mem_addr));

    assert_pc_step_R11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH) |=> (pc == $past(pc) + 8'd1));

    assert_mem_phase_R11: assert property (@(posedge clk) disable iff (rst)
        (in_exec && (ir[7:4] == 4'h6 || ir[7:4] == 4'h7)) |=> (st == ST_MEM));

    assert_set_zext_R3: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir[7:4] == 4'h1) |=> (acc == {4'h0, $past(ir[3:0])}));

    assert_shift_in_R6: assert property (@(posedge clk) disable iff (rst)
        (in_exec && ir[7:4] == 4'h4) |=> (acc == {$past(acc[3:0]), $past(ir[3:0])}));

    assert_single_write_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    assert_undef_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        (in_exec && (ir[7:4] == 4'h0 || (ir[7:4] >= 4'hB && ir[7:4] <= 4'hE)))
        |=> (acc == $past(acc) && base == $past(base) && !mem_we));
endmodule

bind nibcpu_top nibcpu_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .st       (state),
    .ir       (ir),
    .acc      (acc),
    .base     (base),
    .pc       (pc),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halted   (halted)
);

// File: tb/nibcpu_top_bench.sv
module nibcpu_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_addr, mem_rdata, mem_wdata, acc_o, base_o;
    logic       mem_we, halted;

    logic [7:0] mem [256];
    int checks = 0;
    int failures = 0;
    int writes = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nibcpu_top u_nibcpu_top (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .acc_o(acc_o),
        .base_o(base_o), .halted(halted)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            writes <= writes + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        writes = 0;
    endtask

    task automatic release_reset();
        rst = 1'b0;
    endtask

    task automatic run_halt(output int cyc);
        cyc = 0;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) chk("R12 halt reached", 0, 1);
    endtask

    task automatic test_reset();
        int cyc;
        hold_reset();
        clear_mem();
        mem[0] = 8'h1A; mem[1] = 8'h50; mem[2] = 8'hF0;
        release_reset();
        run_halt(cyc);
        hold_reset();
        chk("R1 acc", acc_o, 8'h00);
        chk("R1 base", base_o, 8'h00);
        chk("R1 halted", halted, 0);
        chk("R1 addr", mem_addr, 8'h00);
        chk("R1 we", mem_we, 0);
    endtask

    task automatic test_nibble_build();
        int cyc;
        hold_reset(); clear_mem();
        mem[0] = 8'h19; mem[1] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R3 set zext", acc_o, 8'h09);
        hold_reset(); clear_mem();
        mem[0] = 8'h19; mem[1] = 8'h24; mem[2] = 8'h3F; mem[3] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R5 set/shl/or 9F", acc_o, 8'h9F);
        hold_reset(); clear_mem();
        mem[0] = 8'h1F; mem[1] = 8'h21; mem[2] = 8'h20; mem[3] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R4 shl 1 then 0", acc_o, 8'h1E);
        hold_reset(); clear_mem();
        mem[0] = 8'h1F; mem[1] = 8'h29; mem[2] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R4 shl by 9", acc_o, 8'h00);
    endtask

    task automatic test_shift_in();
        int cyc;
        hold_reset(); clear_mem();
        mem[0] = 8'h49; mem[1] = 8'h4F; mem[2] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R6 shin 9F", acc_o, 8'h9F);
        hold_reset(); clear_mem();
        mem[0] = 8'h1A; mem[1] = 8'h43; mem[2] = 8'h4C; mem[3] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R6 shin drops high", acc_o, 8'h3C);
    endtask

    task automatic test_pool();
        int cyc;
        hold_reset(); clear_mem();
        mem[0] = 8'h1F; mem[1] = 8'h48; mem[2] = 8'h50; mem[3] = 8'h63;
        mem[4] = 8'hF0; mem[8'hFB] = 8'hA5;
        release_reset(); run_halt(cyc);
        chk("R7 base copy", base_o, 8'hF8);
        chk("R8 load pool", acc_o, 8'hA5);
        hold_reset(); clear_mem();
        mem[0] = 8'h1F; mem[1] = 8'h4C; mem[2] = 8'h50; mem[3] = 8'h66;
        mem[4] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R8 load wrap", acc_o, 8'h50);
        chk("R7 base FC", base_o, 8'hFC);
    endtask

    task automatic test_store();
        int cyc;
        hold_reset(); clear_mem();
        mem[0] = 8'h17; mem[1] = 8'h40; mem[2] = 8'h50; mem[3] = 8'h15;
        mem[4] = 8'h73; mem[5] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R9 store data", mem[8'h73], 8'h05);
        chk("R9 neighbour low", mem[8'h72], 8'h00);
        chk("R9 neighbour high", mem[8'h74], 8'h00);
        chk("R9 one write", writes, 1);
        hold_reset(); clear_mem();
        mem[0] = 8'h1F; mem[1] = 8'h4E; mem[2] = 8'h50; mem[3] = 8'h19;
        mem[4] = 8'h75; mem[5] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R9 store wrap", mem[8'h03], 8'h09);
    endtask

    task automatic test_arith();
        int cyc;
        hold_reset(); clear_mem();
        mem[0] = 8'h1F; mem[1] = 8'h4F; mem[2] = 8'h82; mem[3] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R10 add wrap", acc_o, 8'h01);
        hold_reset(); clear_mem();
        mem[0] = 8'h1F; mem[1] = 8'h4F; mem[2] = 8'h82; mem[3] = 8'h47;
        mem[4] = 8'hAF; mem[5] = 8'h9C; mem[6] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R10 add/xor/and", acc_o, 8'h08);
    endtask

    task automatic test_timing_halt();
        int cyc;
        logic [7:0] a0;
        hold_reset(); clear_mem();
        mem[0] = 8'h14; mem[1] = 8'h50; mem[2] = 8'h60; mem[3] = 8'h7F;
        mem[4] = 8'hB0; mem[5] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R11 cycle count", cyc, 14);
        chk("R8 load value", acc_o, 8'hB0);
        chk("R9 store mixed", mem[8'h13], 8'hB0);
        a0 = mem_addr;
        repeat (20) @(negedge clk);
        chk("R12 still halted", halted, 1);
        chk("R12 addr frozen", mem_addr, a0);
        chk("R12 no writes", writes, 1);
    endtask

    task automatic test_undef();
        int cyc;
        hold_reset(); clear_mem();
        mem[0] = 8'h16; mem[1] = 8'h50; mem[2] = 8'h0F; mem[3] = 8'hB3;
        mem[4] = 8'hC7; mem[5] = 8'hDA; mem[6] = 8'hEE; mem[7] = 8'hF0;
        release_reset(); run_halt(cyc);
        chk("R13 acc kept", acc_o, 8'h06);
        chk("R13 base kept", base_o, 8'h06);
        chk("R13 no write", writes, 0);
        chk("R13 cycles", cyc, 16);
    endtask

    task automatic test_pc_wrap();
        hold_reset(); clear_mem();
        mem[0] = 8'h41; mem[8'hFF] = 8'h42;
        release_reset();
        repeat (511) @(negedge clk);
        chk("R11 before last", acc_o, 8'h01);
        @(negedge clk);
        chk("R11 at 0xFF", acc_o, 8'h12);
        repeat (2) @(negedge clk);
        chk("R11 pc wrap", acc_o, 8'h21);
        chk("R2 opcode field", halted, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        clear_mem();
        test_reset();
        test_nibble_build();
        test_shift_in();
        test_pool();
        test_store();
        test_arith();
        test_timing_halt();
        test_reset();
        test_undef();
        test_pc_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule